// File: doc/BRIEF.md
# Microsecond Compare Timer

This block is a 32-bit up-counter that advances once per microsecond. A built-in prescaler divides the system clock down to a one-cycle tick. Software programs a compare value and a set of control bits through a small word-wide register port. When the counter reaches the compare value, three things happen: an interrupt status flag is set, a four-bit event counter steps, and, if the restart option is selected, the counter returns to zero.

With the restart option on, a compare value of N gives a periodic event every N microseconds. With it off, the counter runs past the compare value and wraps at its full width. The interrupt line is a level. It is high while the status flag is set and interrupts are enabled. Software clears the flag or the event counter by writing 1 to the matching write-only control bits.

Top module: `usec_tick_timer`

## Requirements
- R1: After reset the control register, the compare register and the counter all read 0, and `irq` is low.
- R2: While control bit 0 (run) is 1, the counter advances by one once every CLK_PER_US clock cycles. The first step comes CLK_PER_US cycles after run is written to 1. While run is 0 the counter holds its value.
- R3: A match occurs on a tick when the counter's next value equals the compare register. A match sets the status flag (control bit 10, read-only) and adds one to the 4-bit event count (control bits 7:4, read-only), which wraps from 15 to 0.
- R4: With control bit 1 (restart) at 1, a match loads the counter with 0. A compare value of N then gives one match every N ticks.
- R5: With restart at 0, a match does not disturb the count, and the counter continues past the compare value.
- R6: `irq` is high exactly when control bit 8 (interrupt enable) is 1 and the status flag is set.
- R7: Writing 1 to control bit 9 clears the status flag. If a match happens in the same cycle, the flag stays set.
- R8: Writing 1 to control bit 2 clears the event count. If a match happens in the same cycle, the count becomes 1. Bit 2 always reads 0, and so does bit 9.
- R9: The register map is: address 0 control, address 1 compare (read/write), address 2 counter (read-only), address 3 reads 0. Control bits 3, 11 to 31 and the two clear bits read 0.
- R10: A counter value that lasts for several clock cycles produces only one match, so each match adds exactly one to the event count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
A register write takes effect on the edge that samples it, and reads are combinational, so a write shows up in the read-back in the same cycle. After run is written, the k-th counter step and any match it causes land on the edge CLK_PER_US·k cycles later. The status flag, the event count and `irq` follow on that same edge. The bench counts edges from the write's edge, samples on the falling edge of the cycle when a result is due (and of the cycle before, where it needs to see that nothing changed early), and times the race-case writes to land exactly on a match edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned DATA_W      = 32;
   localparam int unsigned ADDR_W      = 2;
   localparam int unsigned BIT_RUN     = 0;
   localparam int unsigned BIT_RESTART = 1;
   localparam int unsigned BIT_CLR_EVT = 2;
   localparam int unsigned EVT_LSB     = 4;
   localparam int unsigned EVT_FIELD_W = 4;
   localparam int unsigned BIT_IRQ_EN  = 8;
   localparam int unsigned BIT_CLR_STS = 9;
   localparam int unsigned BIT_STS     = 10;

   typedef enum logic [ADDR_W-1:0] {
      ADR_CTRL  = 2'd0,
      ADR_CMP   = 2'd1,
      ADR_COUNT = 2'd2,
      ADR_SPARE = 2'd3
   } tmr_addr_e;

   typedef struct packed {
      logic run;
      logic restart;
      logic irq_en;
   } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int unsigned DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   initial begin
      if (DIV < 1) $error("tmr_prescaler: DIV must be at least 1");
   end

   generate
      if (DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_divide
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] phase;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase <= '0;
            end else if (!run) begin
               phase <= '0;
            end else if (phase == LAST) begin
               phase <= '0;
            end else begin
               phase <= phase + 1'b1;
            end
         end

         assign tick = run && (phase == LAST);
      end
   endgenerate
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] cmp,
   output logic [CNT_W-1:0] count,
   output logic             hit
);
   logic [CNT_W-1:0] next_val;

   assign next_val = count + 1'b1;
   assign hit      = tick && (next_val == cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (tick) begin
         if (hit && restart) begin
            count <= '0;
         end else begin
            count <= next_val;
         end
      end
   end
endmodule

// File: rtl/tmr_event.sv
module tmr_event #(
   parameter int unsigned OVF_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             clr_sts,
   input  logic             clr_evt,
   output logic             sts,
   output logic [OVF_W-1:0] evt
);
   logic [OVF_W-1:0] evt_base;

   assign evt_base = clr_evt ? '0 : evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts <= 1'b0;
         evt <= '0;
      end else begin
         if (hit) begin
            sts <= 1'b1;
         end else if (clr_sts) begin
            sts <= 1'b0;
         end
         evt <= evt_base + OVF_W'(hit);
      end
   end
endmodule

// File: rtl/usec_tick_timer.sv
module usec_tick_timer
   import tmr_pkg::*;
#(
   parameter int unsigned CLK_PER_US   = 200,
   parameter int unsigned CNT_W        = 32,
   parameter int unsigned OVF_W        = 4,
   parameter bit          HAS_COUNT_RD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              irq
);
   initial begin
      if (CNT_W < 2 || CNT_W > DATA_W) $error("usec_tick_timer: CNT_W out of range");
      if (OVF_W < 1 || OVF_W > EVT_FIELD_W) $error("usec_tick_timer: OVF_W out of range");
      if (CLK_PER_US < 1) $error("usec_tick_timer: CLK_PER_US must be at least 1");
   end

   tmr_ctrl_t        ctrl_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] count_q;
   logic             tick;
   logic             hit;
   logic             sts;
   logic [OVF_W-1:0] evt;
   logic             wr_ctrl;
   logic             wr_cmp;
   logic             clr_sts;
   logic             clr_evt;
   logic [DATA_W-1:0] ctrl_rd;
   logic [DATA_W-1:0] count_rd;

   assign wr_ctrl = wr_en && (addr == ADR_CTRL);
   assign wr_cmp  = wr_en && (addr == ADR_CMP);
   assign clr_sts = wr_ctrl && wdata[BIT_CLR_STS];
   assign clr_evt = wr_ctrl && wdata[BIT_CLR_EVT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cmp_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.run     <= wdata[BIT_RUN];
            ctrl_q.restart <= wdata[BIT_RESTART];
            ctrl_q.irq_en  <= wdata[BIT_IRQ_EN];
         end
         if (wr_cmp) begin
            cmp_q <= wdata[CNT_W-1:0];
         end
      end
   end

   tmr_prescaler #(.DIV(CLK_PER_US)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctrl_q.run),
      .tick  (tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .restart (ctrl_q.restart),
      .cmp     (cmp_q),
      .count   (count_q),
      .hit     (hit)
   );

   tmr_event #(.OVF_W(OVF_W)) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .clr_sts (clr_sts),
      .clr_evt (clr_evt),
      .sts     (sts),
      .evt     (evt)
   );

   always_comb begin
      ctrl_rd                        = '0;
      ctrl_rd[BIT_RUN]               = ctrl_q.run;
      ctrl_rd[BIT_RESTART]           = ctrl_q.restart;
      ctrl_rd[EVT_LSB +: OVF_W]      = evt;
      ctrl_rd[BIT_IRQ_EN]            = ctrl_q.irq_en;
      ctrl_rd[BIT_STS]               = sts;
   end

   generate
      if (HAS_COUNT_RD) begin : g_count_rd
         assign count_rd = DATA_W'(count_q);
      end else begin : g_no_count_rd
         assign count_rd = '0;
      end
   endgenerate

   always_comb begin
      unique case (tmr_addr_e'(addr))
         ADR_CTRL:  rdata = ctrl_rd;
         ADR_CMP:   rdata = DATA_W'(cmp_q);
         ADR_COUNT: rdata = count_rd;
         default:   rdata = '0;
      endcase
   end

   assign irq = ctrl_q.irq_en & sts;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned OVF_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             hit,
   input logic             run,
   input logic             restart,
   input logic             irq_en,
   input logic             clr_sts,
   input logic             clr_evt,
   input logic [CNT_W-1:0] count,
   input logic             sts,
   input logic [OVF_W-1:0] evt,
   input logic             irq
);
   a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(count));

   a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !hit) |=> (count == CNT_W'($past(count) + 1'b1)));

   a_r3_status_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> sts);

   a_r3_event_step: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !clr_evt) |=> (evt == OVF_W'($past(evt) + 1'b1)));

   a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && restart) |=> (count == '0));

   a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   a_r7_clear_status: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_sts && !hit) |=> !sts);

   a_r8_clear_event: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_evt && !hit) |=> (evt == '0));

   a_r8_clear_race: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_evt && hit) |=> (evt == OVF_W'(1)));

   a_r10_match_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> tick);
endmodule

bind usec_tick_timer tmr_checker #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .hit     (hit),
   .run     (ctrl_q.run),
   .restart (ctrl_q.restart),
   .irq_en  (ctrl_q.irq_en),
   .clr_sts (clr_sts),
   .clr_evt (clr_evt),
   .count   (count_q),
   .sts     (sts),
   .evt     (evt),
   .irq     (irq)
);

// File: tb/sim_usec_tick_timer.sv
module sim_usec_tick_timer;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int unsigned DIV = 4;
   localparam logic [31:0] RUN = 32'h1, RST = 32'h2, CEV = 32'h4, IEN = 32'h100, CST = 32'h200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          n_chk = 0;
   int          n_fail = 0;
   int          cyc = 0;
   int          e0 = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   usec_tick_timer #(.CLK_PER_US(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      e0 = cyc;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wait_to(input int c);
      while (cyc < c) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
      rd(2'd1, v); chk("R1 compare", v, 32'h0);
      rd(2'd2, v); chk("R1 counter", v, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_run_hold();
      logic [31:0] v;
      int s;
      do_reset();
      wr(2'd0, RUN);
      s = e0;
      wait_to(s + 2*DIV - 1); rd(2'd2, v); chk("R2 before step", v, 32'd1);
      wait_to(s + 2*DIV);     rd(2'd2, v); chk("R2 step", v, 32'd2);
      wr(2'd0, 32'h0);
      wait_to(e0 + 30); rd(2'd2, v); chk("R2 hold", v, 32'd2);
   endtask

   task automatic t_restart();
      logic [31:0] v;
      int s;
      do_reset();
      wr(2'd1, 32'd5);
      wr(2'd0, RUN | RST);
      s = e0;
      wait_to(s + 5*DIV - 1); rd(2'd0, v); chk("R3 no early status", v, RUN | RST);
      wait_to(s + 5*DIV);     rd(2'd0, v); chk("R3 status+event", v, RUN | RST | 32'h410);
      chk("R6 irq masked", {31'b0, irq}, 32'h0);
      rd(2'd2, v); chk("R4 counter zero", v, 32'd0);
      wait_to(s + 10*DIV); rd(2'd0, v); chk("R4 period N", v[7:4], 32'd2);
      wr(2'd0, RUN | RST | IEN);
      chk("R6 irq on", {31'b0, irq}, 32'h1);
   endtask

   task automatic t_free_run();
      logic [31:0] v;
      int s;
      do_reset();
      wr(2'd1, 32'd3);
      wr(2'd0, RUN | IEN);
      s = e0;
      wait_to(s + 3*DIV); rd(2'd2, v); chk("R5 counter at match", v, 32'd3);
      chk("R6 irq set", {31'b0, irq}, 32'h1);
      wait_to(s + 4*DIV); rd(2'd2, v); chk("R5 passes compare", v, 32'd4);
      wait_to(s + 40); rd(2'd0, v); chk("R10 one event", v[7:4], 32'd1);
   endtask

   task automatic t_clear_status();
      logic [31:0] v;
      int s;
      do_reset();
      wr(2'd1, 32'd2);
      wr(2'd0, RUN | RST | IEN);
      s = e0;
      wait_to(s + 2*DIV + 1);
      wr(2'd0, RUN | RST | IEN | CST);
      rd(2'd0, v); chk("R7 cleared", v[10], 32'd0);
      chk("R7 irq low", {31'b0, irq}, 32'h0);
      wait_to(s + 4*DIV - 1);
      wr(2'd0, RUN | RST | IEN | CST);
      rd(2'd0, v); chk("R7 match wins", v[10], 32'd1);
      chk("R8 clear bit reads 0", v[9], 32'd0);
   endtask

   task automatic t_event_count();
      logic [31:0] v;
      int s;
      do_reset();
      wr(2'd1, 32'd2);
      wr(2'd0, RUN | RST);
      s = e0;
      wait_to(s + 15*2*DIV); rd(2'd0, v); chk("R3 count 15", v[7:4], 32'd15);
      wait_to(s + 16*2*DIV); rd(2'd0, v); chk("R3 wrap", v[7:4], 32'd0);
      wait_to(s + 17*2*DIV + 1);
      wr(2'd0, RUN | RST | CEV);
      rd(2'd0, v); chk("R8 cleared", v, RUN | RST | 32'h400);
      wait_to(s + 18*2*DIV - 1);
      wr(2'd0, RUN | RST | CEV);
      rd(2'd0, v); chk("R8 race gives 1", v[7:4], 32'd1);
   endtask

   task automatic t_map();
      logic [31:0] v;
      do_reset();
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v); chk("R9 ctrl mask", v, 32'h0000_0103);
      wr(2'd0, 32'h0);
      wr(2'd1, 32'hDEAD_BEEF);
      rd(2'd1, v); chk("R9 compare", v, 32'hDEAD_BEEF);
      rd(2'd3, v); chk("R9 spare", v, 32'h0);
      wr(2'd2, 32'h1234);
      rd(2'd2, v); chk("R9 counter read-only", v, 32'h0);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_run_hold();
      t_restart();
      t_free_run();
      t_clear_status();
      t_event_count();
      t_map();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule